// File: doc/BRIEF.md
# Prioritised Edge/Level Interrupt Controller

This block gathers up to 32 interrupt request lines and presents them to a processor on two outputs: a normal one and a fast one. Each line has its own configuration word. The word selects how the line is detected (a rising transition, or an active level), which output the line belongs to, and a 5-bit priority. A smaller priority value is more urgent. Requests are captured in a pending register. A per-line mask register hides requests from arbitration without discarding them.

Each output is guarded by an arm flag, which reset sets. When the flag is set and an unmasked pending request exists for that output's class, the output goes high, the flag clears, and the number of the winning line is latched into that class's code register. Software services the interrupt by reading the code register. Reading the code of a transition-detected line also acknowledges it. Software then writes the control register to re-arm the class. Re-arming drops the output, and the class is arbitrated again straight away. Software can also inject a request on one line through the software-set register.

The register port is 32 bits wide with byte addresses. A read returns its data in the same cycle. Any side effect of an access takes hold at the clock edge that ends the access.

Top module: `prio_intc`

## Requirements
- R1: After reset the mask register reads 0xFFFFFFFF. The pending register and every configuration word read 0, both outputs are low, and the control register (0x18) always reads 0.
- R2: A line with sensitivity bit 0 becomes pending only when its input goes from low to high. It stays pending after the input drops, until it is acknowledged or cleared.
- R3: A line with sensitivity bit 1 is pending whenever its input is high. Its pending bit clears in the cycle after the input falls.
- R4: A write to the pending register (0x00) ANDs the written data into it. A clear is ignored for a level line whose input is still high.
- R5: A masked line (mask bit 1, register 0x04) never raises an output. Writing 0 to the mask bit of a line that is already pending lets that line raise its output.
- R6: Once an output is high it stays high, and its code stays unchanged, until its class is re-armed. This holds even if more urgent requests arrive in the meantime.
- R7: The latched code is the unmasked pending line of the class with the smallest priority value. Among lines with equal priority, the highest line number wins.
- R8: Configuration bit 0 routes a line to the fast output (1) or to the normal output (0). The two classes arbitrate and re-arm independently.
- R9: Control bit 0 re-arms the normal class and bit 1 re-arms the fast class. If no candidate remains, the output is low in the next cycle. If candidates remain, the output stays high and the code changes to the new winner.
- R10: Reading 0x10 returns the normal code and reading 0x14 returns the fast code. The read clears the pending bit of that line only if the line is edge-sensitive.
- R11: A write to 0x9C requests the lowest set bit of the written data only. For an edge line whose input is already high, the request is ignored.
- R12: The configuration word of line n sits at 0x1C + 4·n. Bits [6:2] hold the priority, bit 1 the sensitivity and bit 0 the routing; other bits read 0. Writes to 0x10 and 0x14 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | Request inputs, active high, synchronous to clk |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_norm | output | 1 | Normal-class interrupt to the processor |
| irq_fast | output | 1 | Fast-class interrupt to the processor |

## Verification
The assertions assume that the request inputs are already synchronous to `clk`. They also assume that a rising input is seen for at least one full cycle, so that the transition check can relate each new pending bit to an input edge or a software-set write one cycle earlier. The bench drives every input and every bus field half a cycle away from the active edge, and it holds reset for several cycles before any check. It issues only one access per cycle, so a code read and a re-arm never share an edge. It also arbitrates between lines by parking requests behind the mask and then releasing them with a single mask write.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
    // byte offsets of the register window
    localparam int unsigned OFF_PEND   = 32'h00;
    localparam int unsigned OFF_MASK   = 32'h04;
    localparam int unsigned OFF_CODE_N = 32'h10;
    localparam int unsigned OFF_CODE_F = 32'h14;
    localparam int unsigned OFF_CTRL   = 32'h18;
    localparam int unsigned OFF_CFG    = 32'h1C;
    localparam int unsigned OFF_SWSET  = 32'h9C;
    // output classes: index 0 normal, index 1 fast
    localparam int NCLS     = 2;
    localparam int CLS_NORM = 0;
    localparam int CLS_FAST = 1;
endpackage

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
    parameter int N  = 32,
    parameter int PW = 5,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]         cand,
    input  logic [N-1:0][PW-1:0] prio,
    output logic                 any,
    output logic [IW-1:0]        win
);
    logic [PW-1:0] best;

    // ascending scan with <= : on equal priority the higher line replaces the lower
    always_comb begin
        any  = 1'b0;
        win  = '0;
        best = '1;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!any || prio[i] <= best)) begin
                any  = 1'b1;
                best = prio[i];
                win  = IW'(i);
            end
        end
    end
endmodule

// File: rtl/intc_pend_bank.sv
module intc_pend_bank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_in,
    input  logic [N-1:0] sens,     // 1 = level, 0 = edge
    input  logic         clr_en,
    input  logic [N-1:0] clr_val,
    input  logic [N-1:0] ack_vec,
    input  logic [N-1:0] sw_vec,
    output logic [N-1:0] pend_q
);
    typedef struct packed {
        logic [N-1:0] in_q;
        logic [N-1:0] pend;
    } st_t;

    st_t st_d, st_q;
    logic [N-1:0] rise, fall, set_v, p;

    always_comb begin
        rise  = line_in & ~st_q.in_q;
        fall  = st_q.in_q & ~line_in;
        p     = st_q.pend;
        if (clr_en)
            p = p & (clr_val | (sens & line_in));
        p     = p & ~(ack_vec & ~sens);
        p     = p & ~(sens & fall);
        set_v = (~sens & rise) | (sens & line_in) | (sw_vec & ~(~sens & line_in));
        st_d.pend = p | set_v;
        st_d.in_q = line_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q = st_q.pend;

    // R3: a falling level input leaves its line idle next cycle
    a_r3_level_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(sens & st_q.in_q & ~line_in & ~sw_vec)) == '0));

    // R2: a newly pending edge line had a rising input or a software request
    a_r2_edge_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(sens)
                   & ~$past((line_in & ~st_q.in_q) | sw_vec)) == '0));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int N  = 32,
    parameter int PW = 5,
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_lines,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_norm,
    output logic          irq_fast
);
    localparam int IW = $clog2(N);

    typedef struct packed {
        logic [N-1:0]                mask;
        logic [N-1:0]                route;
        logic [N-1:0]                sens;
        logic [N-1:0][PW-1:0]        prio;
        logic [NCLS-1:0]             agr;
        logic [NCLS-1:0]             out;
        logic [NCLS-1:0][IW-1:0]     code;
    } st_t;

    st_t st_d, st_q;

    logic                    wr, rd;
    logic [AW-1:0]           cfg_off;
    logic                    is_cfg;
    logic [IW-1:0]           cfg_idx;
    logic [N-1:0]            pend;
    logic [N-1:0]            ack_vec, sw_vec;
    logic                    pend_wr;
    logic [NCLS-1:0]         rearm;
    logic [NCLS-1:0][N-1:0]  cand;
    logic [NCLS-1:0]         any;
    logic [NCLS-1:0][IW-1:0] win;

    // ---------------- address decode ----------------
    always_comb begin
        wr      = bus_valid && bus_write;
        rd      = bus_valid && !bus_write;
        cfg_off = bus_addr - AW'(OFF_CFG);
        is_cfg  = (bus_addr >= AW'(OFF_CFG)) && (cfg_off[1:0] == 2'b00)
                  && (cfg_off[AW-1:2] < (AW-2)'(N));
        cfg_idx = cfg_off[IW+1:2];
        pend_wr = wr && (bus_addr == AW'(OFF_PEND));
        sw_vec  = (wr && bus_addr == AW'(OFF_SWSET))
                  ? (bus_wdata[N-1:0] & (~bus_wdata[N-1:0] + N'(1))) : '0;
        ack_vec = '0;
        if (rd && bus_addr == AW'(OFF_CODE_N)) ack_vec = N'(1) << st_q.code[CLS_NORM];
        if (rd && bus_addr == AW'(OFF_CODE_F)) ack_vec = N'(1) << st_q.code[CLS_FAST];
        for (int c = 0; c < NCLS; c++)
            rearm[c] = wr && (bus_addr == AW'(OFF_CTRL)) && bus_wdata[c];
    end

    // ---------------- pending capture ----------------
    intc_pend_bank #(.N(N)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (irq_lines),
        .sens    (st_q.sens),
        .clr_en  (pend_wr),
        .clr_val (bus_wdata[N-1:0]),
        .ack_vec (ack_vec),
        .sw_vec  (sw_vec),
        .pend_q  (pend)
    );

    // ---------------- per-class arbitration ----------------
    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        assign cand[c] = pend & ~st_q.mask & ((c == CLS_FAST) ? st_q.route : ~st_q.route);

        intc_prio_pick #(.N(N), .PW(PW), .IW(IW)) u_pick (
            .cand (cand[c]),
            .prio (st_q.prio),
            .any  (any[c]),
            .win  (win[c])
        );

        // R6: a raised output waits for its re-arm
        a_r6_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.out[c] && !rearm[c] |=> st_q.out[c]);

        // R7: a freshly raised code names a line that was a candidate
        a_r7_code_was_candidate: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.out[c]) |-> |($past(cand[c]) & (N'(1) << st_q.code[c])));

        // R9: re-arming with nothing to deliver drops the output
        a_r9_rearm_idle_drops: assert property (@(posedge clk) disable iff (!rst_n)
            rearm[c] && !any[c] |=> !st_q.out[c]);
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        if (wr && bus_addr == AW'(OFF_MASK))
            st_d.mask = bus_wdata[N-1:0];
        if (wr && is_cfg) begin
            st_d.prio[cfg_idx]  = bus_wdata[PW+1:2];
            st_d.sens[cfg_idx]  = bus_wdata[1];
            st_d.route[cfg_idx] = bus_wdata[0];
        end
        for (int c = 0; c < NCLS; c++) begin
            if ((st_q.agr[c] || rearm[c]) && any[c]) begin
                st_d.out[c]  = 1'b1;
                st_d.agr[c]  = 1'b0;
                st_d.code[c] = win[c];
            end else if (rearm[c]) begin
                st_d.out[c]  = 1'b0;
                st_d.agr[c]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
            st_q.agr  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        if (is_cfg)
            bus_rdata = DW'({st_q.prio[cfg_idx], st_q.sens[cfg_idx], st_q.route[cfg_idx]});
        else if (bus_addr == AW'(OFF_PEND))   bus_rdata = DW'(pend);
        else if (bus_addr == AW'(OFF_MASK))   bus_rdata = DW'(st_q.mask);
        else if (bus_addr == AW'(OFF_CODE_N)) bus_rdata = DW'(st_q.code[CLS_NORM]);
        else if (bus_addr == AW'(OFF_CODE_F)) bus_rdata = DW'(st_q.code[CLS_FAST]);
    end

    assign irq_norm = st_q.out[CLS_NORM];
    assign irq_fast = st_q.out[CLS_FAST];
endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_lines = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_norm, irq_fast;
    int          n_run = 0;
    int          n_fail = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;   // 125 MHz

    prio_intc u_dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_norm(irq_norm), .irq_fast(irq_fast)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic t_reset();
        rd(8'h04, rv); chk("R1 mask", rv, 32'hFFFF_FFFF);
        rd(8'h00, rv); chk("R1 pending", rv, 0);
        rd(8'h30, rv); chk("R1 cfg line5", rv, 0);
        rd(8'h18, rv); chk("R1 control", rv, 0);
        chk("R1 outputs", {30'd0, irq_fast, irq_norm}, 0);
    endtask

    task automatic t_edge();
        wr(8'h04, 32'h0);
        irq_lines[3] = 1'b1; tick(2);
        chk("R2 out", irq_norm, 1);
        rd(8'h00, rv); chk("R2 pending", rv, 32'h8);
        irq_lines[3] = 1'b0; tick(2);
        rd(8'h00, rv); chk("R2 stays pending", rv, 32'h8);
        rd(8'h10, rv); chk("R10 code", rv, 3);
        rd(8'h00, rv); chk("R10 edge ack", rv, 0);
        wr(8'h18, 32'h1);
        chk("R9 idle drop", irq_norm, 0);
    endtask

    task automatic t_level();
        wr(8'h38, 32'h2);               // line 7 level
        irq_lines[7] = 1'b1; tick(2);
        chk("R3 out", irq_norm, 1);
        wr(8'h00, 32'h0);
        rd(8'h00, rv); chk("R4 level clear ignored", rv, 32'h80);
        rd(8'h10, rv); chk("R10 code level", rv, 7);
        rd(8'h00, rv); chk("R10 level not acked", rv, 32'h80);
        irq_lines[7] = 1'b0; tick(2);
        rd(8'h00, rv); chk("R3 drop clears", rv, 0);
        wr(8'h18, 32'h1);
        irq_lines[3] = 1'b1; tick(2);
        rd(8'h00, rv); chk("R2 edge again", rv, 32'h8);
        wr(8'h00, 32'hFFFF_FFF7);
        rd(8'h00, rv); chk("R4 edge clear", rv, 0);
        wr(8'h18, 32'h1);
        chk("R9 drop", irq_norm, 0);
        irq_lines[3] = 1'b0;
    endtask

    task automatic t_prio();
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h24, 32'd20);              // line 2 prio 5
        wr(8'h44, 32'd12);              // line 10 prio 3
        wr(8'h6C, 32'd12);              // line 20 prio 3
        irq_lines[2] = 1'b1; irq_lines[10] = 1'b1; irq_lines[20] = 1'b1; tick(2);
        chk("R5 masked no out", irq_norm, 0);
        rd(8'h00, rv); chk("R5 masked pending kept", rv, 32'h0010_0404);
        wr(8'h04, 32'h0); tick(2);
        chk("R5 unmask raises", irq_norm, 1);
        rd(8'h10, rv); chk("R7 tie high line", rv, 20);
        irq_lines[30] = 1'b1; tick(2);
        chk("R6 out held", irq_norm, 1);
        rd(8'h10, rv); chk("R6 code held", rv, 20);
        wr(8'h18, 32'h1);
        chk("R9 stays high", irq_norm, 1);
        rd(8'h10, rv); chk("R9 new winner", rv, 30);
        wr(8'h18, 32'h1);
        rd(8'h10, rv); chk("R7 next", rv, 10);
        wr(8'h18, 32'h1);
        rd(8'h10, rv); chk("R7 lowest", rv, 2);
        wr(8'h18, 32'h1);
        chk("R9 all served", irq_norm, 0);
        irq_lines = '0; tick(2);
        rd(8'h00, rv); chk("R10 all acked", rv, 0);
    endtask

    task automatic t_fast();
        wr(8'h4C, 32'h1);               // line 12 fast
        irq_lines[12] = 1'b1; tick(2);
        chk("R8 fast out", irq_fast, 1);
        chk("R8 normal quiet", irq_norm, 0);
        rd(8'h14, rv); chk("R10 fast code", rv, 12);
        wr(8'h18, 32'h1);
        chk("R8 independent rearm", irq_fast, 1);
        wr(8'h18, 32'h2);
        chk("R9 fast drop", irq_fast, 0);
        irq_lines[12] = 1'b0;
    endtask

    task automatic t_sw();
        wr(8'h9C, 32'h0000_0140);
        rd(8'h00, rv); chk("R11 lowest bit", rv, 32'h40);
        rd(8'h10, rv); chk("R11 code", rv, 6);
        wr(8'h18, 32'h1);
        chk("R11 served", irq_norm, 0);
        wr(8'h04, 32'hFFFF_FFFF);
        irq_lines[9] = 1'b1; tick(1);
        wr(8'h00, 32'hFFFF_FDFF);
        wr(8'h9C, 32'h0000_0200);
        rd(8'h00, rv); chk("R11 edge active ignored", rv, 0);
        irq_lines[9] = 1'b0;
        wr(8'h04, 32'h0); tick(2);
        chk("R11 no out", irq_norm, 0);
    endtask

    task automatic t_cfg();
        wr(8'h98, 32'hFFFF_FFFF);
        rd(8'h98, rv); chk("R12 cfg line31", rv, 32'h7F);
        wr(8'h10, 32'h1F);
        rd(8'h10, rv); chk("R12 code write ignored", rv, 6);
        wr(8'h98, 32'h0);
        rd(8'h98, rv); chk("R12 cfg cleared", rv, 0);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_edge();
        t_level();
        t_prio();
        t_fast();
        t_sw();
        t_cfg();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule